// File: doc/BRIEF.md
# Run-Length Infrared Transmitter with Carrier Gating

This block turns a stream of run-length entries into an infrared drive waveform. Each entry is a mark/space flag plus a count of sample periods. The host writes entries into a pair of holding slots, one after the other. While the transmitter is enabled, it plays the slots in the order they were filled. Each time it takes an entry out of a slot it raises a one-cycle interrupt, so the host knows a slot is free for the next entry. Once the last run ends and no entry is waiting, it raises one more interrupt to signal completion.

During mark runs the drive is chopped by a carrier generator. The carrier period and its high width are programmed in half-microsecond units, and an invert bit swaps the two phases. A period of zero turns the carrier off, so a mark run drives steadily high. A two-bit emitter mask selects which of the two emitter pins carry the waveform.

Time is divided into half-microsecond units by a prescaler that runs only while the transmitter is enabled. Dropping the enable therefore pauses playback exactly where it stood.

Top module: `ir_rl_transmitter`

## Requirements
- R1: After reset both emitter pins and the interrupt are low, the emitter mask is 2'b11, the carrier period is 32 units, the high width is 16 units and the invert bit is 0.
- R2: An entry with pulse flag 1 (mark) drives the enabled emitters for count × SAMPLE_UNITS units, gated by the carrier. An entry with pulse flag 0 (space) holds them low for the same time. Consecutive entries follow one another with no gap.
- R3: An entry whose count field is 0 plays for exactly one sample period.
- R4: The largest count, 2^RL_CNT_W−1, plays for its full length.
- R5: With a nonzero period P, a mark output is high for the first H units of every P-unit carrier cycle, where H is the high width. The carrier phase continues across consecutive mark entries without restarting.
- R6: With a carrier period of 0, mark runs drive steadily high.
- R7: A high width of 0 is treated as 1 unit.
- R8: With the invert bit set, each carrier cycle starts with H low units and is high for the rest.
- R9: The interrupt pulses once for every entry taken from a slot, plus once more when a run ends with no entry waiting. N entries give N+1 pulses.
- R10: Entries are written alternately to slot 0 and slot 1 and are played in the order written. The host may write a new entry after each interrupt.
- R11: Bit 0 of the mask enables emitter 0 and bit 1 enables emitter 1. A mask write of zero, or one with any bit at or above bit 2 set, is ignored.
- R12: While the enable is low both emitters stay low and playback is frozen. Raising the enable again resumes the run, so the total high time is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable; low pauses playback |
| ent_wr | input | 1 | Write strobe for one run-length entry |
| ent_pulse | input | 1 | Entry flag: 1 = mark, 0 = space |
| ent_count | input | RL_CNT_W | Entry length in sample periods (0 acts as 1) |
| car_wr | input | 1 | Write strobe for the carrier settings |
| car_period | input | CAR_W | Carrier period in half-microsecond units (0 = no carrier) |
| car_high | input | CAR_W | Carrier high width in half-microsecond units |
| car_invert | input | 1 | Swaps the high and low phases of the carrier |
| mask_wr | input | 1 | Write strobe for the emitter mask |
| mask_in | input | MASK_IN_W | New emitter mask value |
| emit | output | N_EMIT | Emitter drive outputs |
| irq | output | 1 | One-cycle interrupt when a slot is freed or playback drains |

## Verification
The bench measures every stretch of constant level on emitter 0 and compares it against a queue of lengths built from the entries and the carrier settings. This catches:
- a design that restarts the carrier phase at an entry boundary, since the carrier segments break up differently;
- a design that leaves a gap between entries;
- a design that plays a zero count as nothing, or as a very long run;
- a design that does not floor a zero high width to one unit;
- a design that ignores the invert bit.

Interrupts are counted per transmission, so a missing drain pulse or a doubled pulse shows up as a count other than N+1. Masked-off emitters are checked to stay silent, including after illegal mask writes that a faulty design would take. A mid-run pause checks that the output is held low and that no high time is lost or added across the pause.

// File: rtl/ir_rlt_pkg.sv
package ir_rlt_pkg;
  // width of the run-length count field in one entry
  localparam int unsigned RL_CNT_W       = 7;
  // carrier settings after reset: 32 half-us units (~62.5 kHz), half duty
  localparam int unsigned CAR_PERIOD_RST = 32;
  localparam int unsigned CAR_HIGH_RST   = 16;

  typedef struct packed {
    logic                pulse;
    logic [RL_CNT_W-1:0] count;
  } rl_entry_t;
endpackage

// File: rtl/ir_rlt_prescale.sv
module ir_rlt_prescale #(
  parameter int unsigned DIV = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = run;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      logic [PW-1:0] pc_q;
      always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else if (run) pc_q <= (pc_q == PW'(DIV - 1)) ? '0 : pc_q + PW'(1);
      end
      // counter only advances while run is high, so a pause keeps the phase
      assign tick = run && (pc_q == PW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/ir_rlt_sequencer.sv
module ir_rlt_sequencer
  import ir_rlt_pkg::*;
#(
  parameter int unsigned SAMPLE_UNITS = 100
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tx_en,
  input  logic      tick,
  input  logic      wr_en,
  input  rl_entry_t wr_entry,
  output logic      active,
  output logic      pulse,
  output logic      irq
);
  localparam int unsigned UW = (SAMPLE_UNITS > 1) ? $clog2(SAMPLE_UNITS) : 1;
  localparam int unsigned CW = RL_CNT_W;

  rl_entry_t         slot_q [2];
  logic [1:0]        full_q;
  logic              wr_ptr_q, rd_ptr_q;
  logic              active_q, pulse_q, irq_q;
  logic [UW-1:0]     unit_q;
  logic [CW-1:0]     rem_q;

  logic unit_last, run_end, need_next, load, drain;
  rl_entry_t head;

  assign head      = slot_q[rd_ptr_q];
  assign unit_last = (unit_q == UW'(SAMPLE_UNITS - 1));
  assign run_end   = active_q && unit_last && (rem_q == CW'(1));
  assign need_next = !active_q || run_end;
  assign load      = tick && tx_en && need_next && full_q[rd_ptr_q];
  assign drain     = tick && tx_en && run_end && !full_q[rd_ptr_q];

  // slot storage: plain write port, no reset, suits distributed/block RAM
  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_ptr_q] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q   <= '0;
      wr_ptr_q <= 1'b0;
      rd_ptr_q <= 1'b0;
      active_q <= 1'b0;
      pulse_q  <= 1'b0;
      irq_q    <= 1'b0;
      unit_q   <= '0;
      rem_q    <= '0;
    end else begin
      irq_q <= load || drain;
      if (load) begin
        active_q <= 1'b1;
        pulse_q  <= head.pulse;
        rem_q    <= (head.count == '0) ? CW'(1) : head.count;
        unit_q   <= '0;
        rd_ptr_q <= ~rd_ptr_q;
      end else if (drain) begin
        active_q <= 1'b0;
        pulse_q  <= 1'b0;
      end else if (tick && tx_en && active_q) begin
        if (unit_last) begin
          unit_q <= '0;
          rem_q  <= rem_q - CW'(1);
        end else begin
          unit_q <= unit_q + UW'(1);
        end
      end
      if (load) full_q[rd_ptr_q] <= 1'b0;
      if (wr_en) begin
        full_q[wr_ptr_q] <= 1'b1;
        wr_ptr_q         <= ~wr_ptr_q;
      end
    end
  end

  assign active = active_q;
  assign pulse  = pulse_q;
  assign irq    = irq_q;

  // a playing run never holds a zero remaining count (zero counts promoted)
  assert_rem_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (rem_q != '0));

  // disabled transmitter freezes the run position
  assert_pause_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> ($stable(rem_q) && $stable(unit_q) && $stable(active_q)));

  assert_unit_range_R2: assert property (@(posedge clk) disable iff (rst)
    unit_q <= UW'(SAMPLE_UNITS - 1));
endmodule

// File: rtl/ir_rlt_carrier.sv
module ir_rlt_carrier #(
  parameter int unsigned CAR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             modulate,
  input  logic [CAR_W-1:0] period,
  input  logic [CAR_W-1:0] high,
  input  logic             invert,
  output logic             level
);
  logic [CAR_W-1:0] cnt_q;
  logic [CAR_W-1:0] high_eff;

  assign high_eff = (high == '0) ? CAR_W'(1) : high;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!modulate || period == '0) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= (cnt_q >= period - CAR_W'(1)) ? '0 : cnt_q + CAR_W'(1);
    end
  end

  assign level = (period == '0) ? 1'b1 : ((cnt_q < high_eff) ^ invert);

  // first unit of every carrier cycle is the active phase, even for width 0
  assert_high_floor_R7: assert property (@(posedge clk) disable iff (rst)
    (modulate && period != '0 && cnt_q == '0) |-> (level == !invert));
endmodule

// File: rtl/ir_rl_transmitter.sv
module ir_rl_transmitter
  import ir_rlt_pkg::*;
#(
  parameter int unsigned HALF_US_DIV  = 50,
  parameter int unsigned SAMPLE_UNITS = 100,
  parameter int unsigned CAR_W        = 8,
  parameter int unsigned N_EMIT       = 2,
  parameter int unsigned MASK_IN_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tx_en,
  input  logic                ent_wr,
  input  logic                ent_pulse,
  input  logic [RL_CNT_W-1:0] ent_count,
  input  logic                car_wr,
  input  logic [CAR_W-1:0]    car_period,
  input  logic [CAR_W-1:0]    car_high,
  input  logic                car_invert,
  input  logic                mask_wr,
  input  logic [MASK_IN_W-1:0] mask_in,
  output logic [N_EMIT-1:0]   emit,
  output logic                irq
);
  logic [CAR_W-1:0]  period_q, high_q;
  logic              invert_q;
  logic [N_EMIT-1:0] mask_q;
  logic              mask_ok;
  logic              tick, active, pulse, car_level, wave;
  rl_entry_t         wr_entry;

  generate
    if (MASK_IN_W > N_EMIT) begin : g_mask_hi
      assign mask_ok = (mask_in[N_EMIT-1:0] != '0) && (mask_in[MASK_IN_W-1:N_EMIT] == '0);
    end else begin : g_mask_eq
      assign mask_ok = (mask_in[N_EMIT-1:0] != '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= CAR_W'(CAR_PERIOD_RST);
      high_q   <= CAR_W'(CAR_HIGH_RST);
      invert_q <= 1'b0;
      mask_q   <= '1;
    end else begin
      if (car_wr) begin
        period_q <= car_period;
        high_q   <= car_high;
        invert_q <= car_invert;
      end
      if (mask_wr && mask_ok) mask_q <= mask_in[N_EMIT-1:0];
    end
  end

  assign wr_entry.pulse = ent_pulse;
  assign wr_entry.count = ent_count;

  ir_rlt_prescale #(.DIV(HALF_US_DIV)) u_pre (
    .clk(clk), .rst(rst), .run(tx_en), .tick(tick)
  );

  ir_rlt_sequencer #(.SAMPLE_UNITS(SAMPLE_UNITS)) u_seq (
    .clk(clk), .rst(rst), .tx_en(tx_en), .tick(tick),
    .wr_en(ent_wr), .wr_entry(wr_entry),
    .active(active), .pulse(pulse), .irq(irq)
  );

  ir_rlt_carrier #(.CAR_W(CAR_W)) u_car (
    .clk(clk), .rst(rst), .tick(tick), .modulate(active && pulse),
    .period(period_q), .high(high_q), .invert(invert_q), .level(car_level)
  );

  assign wave = tx_en && active && pulse && car_level;

  always_ff @(posedge clk) begin
    if (rst) emit <= '0;
    else     emit <= {N_EMIT{wave}} & mask_q;
  end

  assert_disabled_low_R12: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (emit == '0));

  assert_space_low_R2: assert property (@(posedge clk) disable iff (rst)
    (active && !pulse) |=> (emit == '0));

  assert_steady_mark_R6: assert property (@(posedge clk) disable iff (rst)
    (tx_en && active && pulse && period_q == '0) |=> (emit == $past(mask_q)));

  assert_mask_legal_R11: assert property (@(posedge clk) disable iff (rst)
    mask_q != '0);
endmodule

// File: tb/tb_ir_rl_transmitter.sv
module tb_ir_rl_transmitter;
  import ir_rlt_pkg::*;
  localparam int D  = 2;
  localparam int SU = 10;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0, ent_wr = 1'b0, ent_pulse = 1'b0;
  logic [RL_CNT_W-1:0] ent_count = '0;
  logic car_wr = 1'b0, car_invert = 1'b0, mask_wr = 1'b0;
  logic [CW-1:0] car_period = '0, car_high = '0;
  logic [3:0] mask_in = '0;
  logic [1:0] emit;
  logic irq;

  always #5 clk = ~clk;

  ir_rl_transmitter #(.HALF_US_DIV(D), .SAMPLE_UNITS(SU), .CAR_W(CW),
                      .N_EMIT(2), .MASK_IN_W(4)) dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .ent_wr(ent_wr), .ent_pulse(ent_pulse),
    .ent_count(ent_count), .car_wr(car_wr), .car_period(car_period),
    .car_high(car_high), .car_invert(car_invert), .mask_wr(mask_wr),
    .mask_in(mask_in), .emit(emit), .irq(irq)
  );

  int checks = 0, fails = 0;
  int q_lvl[$], q_len[$];
  int irq_cnt = 0, hi0 = 0, hi1 = 0;
  bit skip_lead = 1'b1, mon_on = 1'b1;
  int cur = 0, run = 0;
  int e_p[8], e_c[8], ne;
  int mP = 32, mH = 16, mpol = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic end_seg(int lvl, int len);
    if (lvl == 0 && skip_lead) skip_lead = 1'b0;
    else if (mon_on) begin
      if (q_lvl.size() == 0) begin
        if (lvl == 1) chk(1'b0, "R2", "unexpected high segment", len, 0);
      end else begin
        int el, en;
        el = q_lvl.pop_front();
        en = q_len.pop_front();
        chk(el == lvl && en == len, "R2/R5", "segment length (level in msb x1000)",
            lvl * 1000 + len, el * 1000 + en);
      end
    end
  endtask

  // monitor: samples away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      irq_cnt += int'(irq);
      hi0 += int'(emit[0]);
      hi1 += int'(emit[1]);
      if (int'(emit[0]) == cur) run++;
      else begin
        end_seg(cur, run);
        cur = int'(emit[0]);
        run = 1;
      end
    end
  end

  // expected segments from entries and carrier settings (requirements R2..R8)
  task automatic build_expect();
    int prev, run_u, c;
    bit started;
    prev = 0; run_u = 0; c = 0; started = 1'b0;
    for (int i = 0; i < ne; i++) begin
      int n;
      n = (e_c[i] == 0) ? 1 : e_c[i];
      for (int u = 0; u < n * SU; u++) begin
        int lv;
        if (e_p[i] == 0) begin lv = 0; c = 0; end
        else if (mP == 0) lv = 1;
        else begin
          int h;
          h = (mH == 0) ? 1 : mH;
          lv = ((c < h) ? 1 : 0) ^ mpol;
          c = (c + 1 >= mP) ? 0 : c + 1;
        end
        if (!started) begin
          if (lv == 1) begin started = 1'b1; prev = 1; run_u = 1; end
        end else if (lv == prev) run_u++;
        else begin
          q_lvl.push_back(prev); q_len.push_back(run_u * D);
          prev = lv; run_u = 1;
        end
      end
    end
    if (started && prev == 1) begin q_lvl.push_back(1); q_len.push_back(run_u * D); end
  endtask

  task automatic wr_ent(int i);
    ent_pulse = e_p[i][0];
    ent_count = RL_CNT_W'(e_c[i]);
    ent_wr = 1'b1;
    @(negedge clk);
    ent_wr = 1'b0;
  endtask

  task automatic set_car(int p, int h, int pol);
    car_period = CW'(p); car_high = CW'(h); car_invert = pol[0];
    car_wr = 1'b1; @(negedge clk); car_wr = 1'b0;
    mP = p; mH = h; mpol = pol;
  endtask

  task automatic set_mask(logic [3:0] m);
    mask_in = m; mask_wr = 1'b1; @(negedge clk); mask_wr = 1'b0;
  endtask

  // driver: primes two slots, refills after each interrupt, checks N+1 pulses
  task automatic play(string req);
    int base, nx;
    skip_lead = 1'b1;
    if (mon_on) build_expect();
    base = irq_cnt;
    nx = (ne < 2) ? ne : 2;
    for (int i = 0; i < nx; i++) wr_ent(i);
    tx_en = 1'b1;
    while (irq_cnt - base < ne + 1) begin
      if (nx < ne && irq_cnt - base >= nx - 1) begin wr_ent(nx); nx++; end
      else @(negedge clk);
    end
    repeat (3 * SU * D) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    chk(irq_cnt - base == ne + 1, "R9", "interrupt pulses per transmission", irq_cnt - base, ne + 1);
    chk(q_lvl.size() == 0, req, "expected segments left unseen", q_lvl.size(), 0);
    q_lvl.delete(); q_len.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int h0, h1, base;
    bit quiet;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(emit == 2'b00, "R1", "emitters after reset", int'(emit), 0);
    chk(irq == 1'b0, "R1", "irq after reset", int'(irq), 0);

    // R1/R5: reset carrier 32/16 over a 40-unit mark, both emitters enabled
    h0 = hi0; h1 = hi1;
    ne = 2; e_p[0] = 1; e_c[0] = 4; e_p[1] = 0; e_c[1] = 1;
    play("R1");
    chk(hi1 - h1 == hi0 - h0 && hi0 != h0, "R1", "emitter1 high time equals emitter0", hi1 - h1, hi0 - h0);

    // R6/R10: no carrier, four entries with refills, order kept
    set_car(0, 0, 0);
    ne = 4; e_p[0] = 1; e_c[0] = 2; e_p[1] = 0; e_c[1] = 3; e_p[2] = 1; e_c[2] = 1; e_p[3] = 0; e_c[3] = 1;
    play("R10");

    // R3: zero counts play one period
    ne = 3; e_p[0] = 1; e_c[0] = 0; e_p[1] = 0; e_c[1] = 0; e_p[2] = 1; e_c[2] = 2;
    play("R3");

    // R4: largest count
    ne = 2; e_p[0] = 1; e_c[0] = 127; e_p[1] = 0; e_c[1] = 1;
    play("R4");

    // R5: carrier phase continues across two mark entries
    set_car(6, 2, 0);
    ne = 3; e_p[0] = 1; e_c[0] = 1; e_p[1] = 1; e_c[1] = 1; e_p[2] = 0; e_c[2] = 1;
    play("R5");

    // R7: zero high width acts as one unit
    set_car(4, 0, 0);
    ne = 2; e_p[0] = 1; e_c[0] = 1; e_p[1] = 0; e_c[1] = 1;
    play("R7");

    // R8: inverted carrier
    set_car(4, 1, 1);
    ne = 2; e_p[0] = 1; e_c[0] = 1; e_p[1] = 0; e_c[1] = 1;
    play("R8");

    // R11: mask routing and rejected mask writes
    set_car(0, 0, 0);
    set_mask(4'b0001);
    h1 = hi1;
    ne = 1; e_p[0] = 1; e_c[0] = 2;
    play("R11");
    chk(hi1 == h1, "R11", "emitter1 high clocks with mask 01", hi1 - h1, 0);
    set_mask(4'b0000);
    set_mask(4'b0100);
    h1 = hi1;
    play("R11");
    chk(hi1 == h1, "R11", "emitter1 after illegal mask writes", hi1 - h1, 0);
    set_mask(4'b0010);
    mon_on = 1'b0;
    h0 = hi0; h1 = hi1;
    play("R11");
    chk(hi0 == h0, "R11", "emitter0 high clocks with mask 10", hi0 - h0, 0);
    chk(hi1 - h1 == 2 * SU * D, "R11", "emitter1 high clocks with mask 10", hi1 - h1, 2 * SU * D);
    set_mask(4'b0011);

    // R12: pause in mid-run keeps outputs low and loses no time
    h0 = hi0; base = irq_cnt;
    ne = 1; e_p[0] = 1; e_c[0] = 5;
    wr_ent(0);
    tx_en = 1'b1;
    repeat (30) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    quiet = 1'b1;
    for (int k = 0; k < 40; k++) begin
      if (emit != 2'b00) quiet = 1'b0;
      @(negedge clk);
    end
    chk(quiet, "R12", "emitters low while disabled", int'(quiet), 1);
    chk(irq_cnt - base == 1, "R12", "interrupts before resume", irq_cnt - base, 1);
    tx_en = 1'b1;
    while (irq_cnt - base < 2) @(negedge clk);
    repeat (10) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    chk(hi0 - h0 == 5 * SU * D, "R12", "total high clocks across pause", hi0 - h0, 5 * SU * D);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule